// File: doc/BRIEF.md
# Loader Entry and Serial Rate Finder

This block decides when a microcontroller enters its program-load state and then works out how the loading host will talk to it. A load request is made by holding the reset pin high and, while reset is already in force, pulling the program-store-enable sense line low. Once the request is accepted, the block waits for whichever of two events comes first. One is a pulse on the parallel program-load input, which selects parallel loading. The other is a carriage-return character (0x0D) on the serial receive line, sent at 9600, 2400, 1200 or 300 bit/s, which selects serial loading at the rate the host used.

To find the rate, the block measures the low start bit. 0x0D is sent least significant bit first and its bit 0 is 1, so the start bit on its own lasts exactly one bit time. The measured width is matched to a window of ±25% around each candidate rate. The block then receives the rest of the frame at that rate and locks only if the byte is 0x0D and the stop bit is high. All bit timing is derived from the `CLK_HZ` parameter. The divisor for each rate is `CLK_HZ / rate`. The loader's command handling and the memory programming sit downstream and use the `locked`, `mode_serial` and `baud_div` outputs.

States: `ST_IDLE` (no request), `ST_ARMED` (request accepted, waiting), `ST_MEASURE` (timing the start bit), `ST_VERIFY` (receiving the frame at the candidate rate), `ST_LOCK_SER` and `ST_LOCK_PAR` (terminal).

Transitions:
- `ST_IDLE` to `ST_ARMED` on entry.
- `ST_ARMED` to `ST_LOCK_PAR` on a program pulse rising edge. This takes priority over a start edge in the same cycle.
- `ST_ARMED` to `ST_MEASURE` on a falling edge of the receive line.
- `ST_MEASURE` to `ST_VERIFY` when the width falls inside a window.
- `ST_MEASURE` to `ST_ARMED` when the width is outside every window, or when the line stays low past the longest window.
- `ST_VERIFY` to `ST_LOCK_SER` on a good frame.
- `ST_VERIFY` to `ST_ARMED` on a bad byte or a bad stop bit.
- Any unlocked state other than `ST_IDLE` to `ST_IDLE` when reset is released.

All inputs pass through a two-stage synchronizer first.

Top module: `loader_autobaud`

## Requirements
- R1: The block leaves idle (`loader_active` = 1) only after a cycle in which the synchronized reset pin is high, the synchronized `psen_n` is low, and reset was also high in the cycle before.
- R2: `psen_n` going low while reset is low, or only in the same cycle that reset first rises, causes no entry. While idle, serial characters and program pulses have no effect on any output.
- R3: In the armed state, a rising edge on `prog_pulse` gives `locked` = 1, `mode_serial` = 0 and `baud_div` = 0.
- R4: A 0x0D frame at 9600, 2400, 1200 or 300 bit/s gives `locked` = 1, `mode_serial` = 1 and `baud_div` = `CLK_HZ/rate` (integer division).
- R5: A start bit of W cycles selects rate divisor D only when D - D/4 <= W <= D + D/4 (integer division). Any other width leads to no lock from that frame.
- R6: The frame is 8 data bits, least significant first, then one stop bit. A byte other than 0x0D, or a stop bit sampled low, clears the candidate and re-arms, so that a later correct frame still locks.
- R7: Releasing reset before lock returns the block to idle (`loader_active` = 0). A later serial frame then does not lock.
- R8: Once locked, `locked`, `mode_serial` and `baud_div` hold until `arst_n` is asserted. This holds even if the reset pin is released.
- R9: While `arst_n` is low, and right after it is released, all outputs are 0.
- R10: The first qualifying event wins. After a serial lock, a program pulse changes nothing. After a parallel lock, a serial 0x0D changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency `CLK_HZ` |
| arst_n | input | 1 | Asynchronous active-low block reset |
| rst_pin | input | 1 | Device reset pin, active high |
| psen_n | input | 1 | Program-store-enable sense line, active low |
| rxd | input | 1 | Serial receive line, idle high |
| prog_pulse | input | 1 | Parallel program-load pulse, active high |
| loader_active | output | 1 | Load request accepted |
| mode_serial | output | 1 | 1 = serial load locked, 0 = parallel or none |
| baud_div | output | DIV_W | Clock cycles per bit of the locked rate, 0 otherwise |
| locked | output | 1 | Loading mode decided |

## Verification
The checker watches several rules on every cycle:
- entry is only ever preceded by reset held for two synchronized cycles together with `psen_n` low;
- a parallel lock carries a zero divisor, and a serial lock carries one of the four legal divisors;
- releasing reset drops an unlocked loader;
- the locked outputs never change.

Whether the width windows sit at the right edges, whether the frame is really decoded least significant bit first, and whether a rejected frame re-arms cleanly can only be shown by the bench. It sweeps the start-bit widths across both edges of the fastest and slowest windows and sends wrong bytes, bad stop bits and competing events.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_MEASURE,
        ST_VERIFY,
        ST_LOCK_SER,
        ST_LOCK_PAR
    } ldr_state_t;

    localparam int NRATES = 4;
    localparam logic [7:0] WAKE_CHAR = 8'h0D;

    // candidate serial rates, index 0 is the fastest
    function automatic int rate_bps(input int idx);
        case (idx)
            0:       return 9600;
            1:       return 2400;
            2:       return 1200;
            default: return 300;
        endcase
    endfunction

endpackage

// File: rtl/ldr_sync.sv
module ldr_sync #(
    parameter int          W      = 4,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stg <= {STAGES{INIT}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ldr_rate_match.sv
module ldr_rate_match
    import ldr_pkg::*;
#(
    parameter int CLK_HZ = 16_000_000,
    parameter int CW     = 18
) (
    input  logic [CW-1:0] width,
    output logic          hit,
    output logic [CW-1:0] div
);
    logic [NRATES-1:0]         in_win;
    logic [NRATES-1:0][CW-1:0] divs;

    for (genvar g = 0; g < NRATES; g++) begin : g_rate
        localparam int D  = CLK_HZ / rate_bps(g);
        localparam int LO = D - D / 4;
        localparam int HI = D + D / 4;
        assign divs[g]   = CW'(D);
        assign in_win[g] = (width >= CW'(LO)) && (width <= CW'(HI));
    end

    always_comb begin
        hit = |in_win;
        div = '0;
        for (int i = NRATES - 1; i >= 0; i--) begin
            if (in_win[i]) div = divs[i];
        end
    end
endmodule

// File: rtl/ldr_bit_timer.sv
module ldr_bit_timer #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    input  logic [CW-1:0] reload_val,
    output logic          tick
);
    logic [CW-1:0] cnt;

    assign tick = run && !load && (cnt == '0);

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run) begin
            cnt <= (cnt == '0) ? reload_val : cnt - 1'b1;
        end
    end
endmodule

// File: rtl/loader_autobaud.sv
module loader_autobaud
    import ldr_pkg::*;
#(
    parameter int CLK_HZ      = 16_000_000,
    parameter int SYNC_STAGES = 2,
    localparam int MAXDIV     = CLK_HZ / 300,
    localparam int MAXHI      = MAXDIV + MAXDIV / 4,
    localparam int DIV_W      = $clog2(MAXHI + 2) + 1
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             rst_pin,
    input  logic             psen_n,
    input  logic             rxd,
    input  logic             prog_pulse,
    output logic             loader_active,
    output logic             mode_serial,
    output logic [DIV_W-1:0] baud_div,
    output logic             locked
);
    localparam int BITS = 8;

    // synchronized inputs {prog, rxd, psen_n, rst}
    logic [3:0] raw_in, syn_in;
    logic rst_s, psen_n_s, rxd_s, prog_s;
    logic rst_q, rxd_q, prog_q;

    assign raw_in = {prog_pulse, rxd, psen_n, rst_pin};

    ldr_sync #(.W(4), .STAGES(SYNC_STAGES), .INIT(4'b0110)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d      (raw_in),
        .q      (syn_in)
    );

    assign rst_s    = syn_in[0];
    assign psen_n_s = syn_in[1];
    assign rxd_s    = syn_in[2];
    assign prog_s   = syn_in[3];

    logic rx_fall, prog_rise, entry_req;
    assign rx_fall   = rxd_q && !rxd_s;
    assign prog_rise = prog_s && !prog_q;
    assign entry_req = rst_s && rst_q && !psen_n_s;

    ldr_state_t      state_q, state_d;
    logic [DIV_W-1:0] width_q;
    logic [DIV_W-1:0] cand_div;
    logic [BITS-1:0]  shreg;
    logic [3:0]       bitn;

    logic             win_hit;
    logic [DIV_W-1:0] win_div;
    logic             too_long;
    logic             width_ok;
    logic             tmr_load, tmr_run, tick;
    logic             frame_good;

    ldr_rate_match #(.CLK_HZ(CLK_HZ), .CW(DIV_W)) u_match (
        .width (width_q),
        .hit   (win_hit),
        .div   (win_div)
    );

    assign too_long = !rxd_s && (width_q >= DIV_W'(MAXHI));
    assign width_ok = (state_q == ST_MEASURE) && rxd_s && win_hit;
    assign tmr_load = width_ok;
    assign tmr_run  = (state_q == ST_VERIFY);

    ldr_bit_timer #(.CW(DIV_W)) u_timer (
        .clk        (clk),
        .arst_n     (arst_n),
        .load       (tmr_load),
        .load_val   ({1'b0, win_div[DIV_W-1:1]}),
        .run        (tmr_run),
        .reload_val (cand_div - 1'b1),
        .tick       (tick)
    );

    assign frame_good = (shreg == WAKE_CHAR) && rxd_s;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (entry_req) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!rst_s)          state_d = ST_IDLE;
                else if (prog_rise)  state_d = ST_LOCK_PAR;
                else if (rx_fall)    state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (!rst_s)          state_d = ST_IDLE;
                else if (rxd_s)      state_d = win_hit ? ST_VERIFY : ST_ARMED;
                else if (too_long)   state_d = ST_ARMED;
            end
            ST_VERIFY: begin
                if (!rst_s)                        state_d = ST_IDLE;
                else if (tick && bitn == 4'(BITS)) state_d = frame_good ? ST_LOCK_SER : ST_ARMED;
            end
            ST_LOCK_SER: state_d = ST_LOCK_SER;
            ST_LOCK_PAR: state_d = ST_LOCK_PAR;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q  <= ST_IDLE;
            rst_q    <= 1'b0;
            rxd_q    <= 1'b1;
            prog_q   <= 1'b0;
            width_q  <= '0;
            cand_div <= '0;
            shreg    <= '0;
            bitn     <= '0;
        end else begin
            state_q <= state_d;
            rst_q   <= rst_s;
            rxd_q   <= rxd_s;
            prog_q  <= prog_s;

            if (state_q == ST_ARMED) begin
                cand_div <= '0;
                width_q  <= rx_fall ? DIV_W'(1) : '0;
            end else if (state_q == ST_MEASURE && !rxd_s) begin
                width_q <= width_q + 1'b1;
            end

            if (width_ok) begin
                cand_div <= win_div;
                bitn     <= '0;
                shreg    <= '0;
            end else if (tmr_run && tick) begin
                bitn <= bitn + 1'b1;
                if (bitn < 4'(BITS)) shreg <= {rxd_s, shreg[BITS-1:1]};
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        loader_active = (state_q != ST_IDLE);
        locked        = (state_q == ST_LOCK_SER) || (state_q == ST_LOCK_PAR);
        mode_serial   = (state_q == ST_LOCK_SER);
        baud_div      = (state_q == ST_LOCK_SER) ? cand_div : '0;
    end
endmodule

// File: rtl/ldr_chk.sv
module ldr_chk
    import ldr_pkg::*;
#(
    parameter int CLK_HZ = 16_000_000,
    parameter int CW     = 18
) (
    input logic          clk,
    input logic          arst_n,
    input logic          rst_s,
    input logic          psen_n_s,
    input logic          loader_active,
    input logic          mode_serial,
    input logic [CW-1:0] baud_div,
    input logic          locked
);
    localparam logic [CW-1:0] D0 = CW'(CLK_HZ / rate_bps(0));
    localparam logic [CW-1:0] D1 = CW'(CLK_HZ / rate_bps(1));
    localparam logic [CW-1:0] D2 = CW'(CLK_HZ / rate_bps(2));
    localparam logic [CW-1:0] D3 = CW'(CLK_HZ / rate_bps(3));

    // R1: entry only after reset held two cycles with psen low
    p_entry_needs_reset_r1: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(loader_active) |-> ($past(rst_s) && $past(rst_s, 2) && !$past(psen_n_s)));

    // R3: parallel lock carries no divisor
    p_par_div_zero_r3: assert property (@(posedge clk) disable iff (!arst_n)
        (locked && !mode_serial) |-> (baud_div == '0));

    // R4: serial lock carries one of the four divisors
    p_ser_div_legal_r4: assert property (@(posedge clk) disable iff (!arst_n)
        mode_serial |-> (locked && (baud_div == D0 || baud_div == D1 ||
                                    baud_div == D2 || baud_div == D3)));

    // R7: releasing reset drops an unlocked loader
    p_release_idle_r7: assert property (@(posedge clk) disable iff (!arst_n)
        (!rst_s && !locked) |=> !loader_active);

    // R8: locked outputs hold
    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!arst_n)
        locked |=> (locked && $stable(mode_serial) && $stable(baud_div)));

    // R8: a lock implies the loader is active
    p_lock_active_r8: assert property (@(posedge clk) disable iff (!arst_n)
        locked |-> loader_active);
endmodule

bind loader_autobaud ldr_chk #(.CLK_HZ(CLK_HZ), .CW(DIV_W)) u_chk (
    .clk           (clk),
    .arst_n        (arst_n),
    .rst_s         (rst_s),
    .psen_n_s      (psen_n_s),
    .loader_active (loader_active),
    .mode_serial   (mode_serial),
    .baud_div      (baud_div),
    .locked        (locked)
);

// File: tb/sim_loader_autobaud.sv
module sim_loader_autobaud;
    localparam int CLK_PERIOD = 10;
    localparam int SIM_HZ     = 96000;
    localparam int MAXD       = SIM_HZ / 300;
    localparam int MAXHI      = MAXD + MAXD / 4;
    localparam int DW         = $clog2(MAXHI + 2) + 1;

    logic clk = 1'b0;
    logic arst_n, rst_pin, psen_n, rxd, prog_pulse;
    logic loader_active, mode_serial, locked;
    logic [DW-1:0] baud_div;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    loader_autobaud #(.CLK_HZ(SIM_HZ)) u0 (
        .clk           (clk),
        .arst_n        (arst_n),
        .rst_pin       (rst_pin),
        .psen_n        (psen_n),
        .rxd           (rxd),
        .prog_pulse    (prog_pulse),
        .loader_active (loader_active),
        .mode_serial   (mode_serial),
        .baud_div      (baud_div),
        .locked        (locked)
    );

    function automatic int rate_of(input int i);
        case (i)
            0: return 9600;
            1: return 2400;
            2: return 1200;
            default: return 300;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        arst_n = 1'b0; rst_pin = 1'b0; psen_n = 1'b1; rxd = 1'b1; prog_pulse = 1'b0;
        wait_n(3);
        arst_n = 1'b1;
        wait_n(2);
    endtask

    task automatic enter;
        @(negedge clk);
        rst_pin = 1'b1; psen_n = 1'b1;
        wait_n(3);
        psen_n = 1'b0;
        wait_n(6);
        psen_n = 1'b1;
        wait_n(2);
    endtask

    task automatic send_frame(input int sw, input int bw, input logic [7:0] b,
                              input logic stopb, input int idle);
        @(negedge clk);
        rxd = 1'b0;
        wait_n(sw);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_n(bw);
        end
        rxd = stopb;
        wait_n(bw);
        rxd = 1'b1;
        wait_n(idle);
    endtask

    task automatic pulse_prog;
        @(negedge clk);
        prog_pulse = 1'b1;
        wait_n(3);
        prog_pulse = 1'b0;
        wait_n(6);
    endtask

    initial begin
        arst_n = 1'b0; rst_pin = 1'b0; psen_n = 1'b1; rxd = 1'b1; prog_pulse = 1'b0;
        wait_n(2);
        // R9: outputs under reset
        check(!loader_active && !locked && !mode_serial && baud_div == 0, "R9 outputs in reset",
              {loader_active, locked, mode_serial}, 0);
        do_reset();
        check(!loader_active && !locked && baud_div == 0, "R9 outputs after reset",
              {loader_active, locked}, 0);

        // R2: psen low without reset
        psen_n = 1'b0; wait_n(10); psen_n = 1'b1; wait_n(4);
        check(!loader_active, "R2 psen without reset", loader_active, 0);

        // R2: psen low only in the first reset cycle
        @(negedge clk); rst_pin = 1'b1; psen_n = 1'b0;
        @(negedge clk); psen_n = 1'b1;
        wait_n(8);
        check(!loader_active, "R2 psen with reset edge only", loader_active, 0);
        // R2: serial and program pulses while idle are ignored
        rst_pin = 1'b0;
        send_frame(10, 10, 8'h0D, 1'b1, 20);
        pulse_prog();
        check(!loader_active && !locked, "R2 idle ignores events", {loader_active, locked}, 0);

        // R1: normal entry
        do_reset();
        enter();
        check(loader_active && !locked, "R1 entry", {loader_active, locked}, 2);

        // R7: release before lock, then serial ignored
        @(negedge clk); rst_pin = 1'b0; wait_n(5);
        check(!loader_active, "R7 release to idle", loader_active, 0);
        send_frame(10, 10, 8'h0D, 1'b1, 20);
        check(!locked, "R7 no lock after release", locked, 0);

        // R3 and R10: parallel pulse, then serial ignored
        do_reset(); enter();
        pulse_prog();
        check(locked && !mode_serial && baud_div == 0, "R3 parallel lock",
              {locked, mode_serial}, 2);
        send_frame(10, 10, 8'h0D, 1'b1, 20);
        check(locked && !mode_serial && baud_div == 0, "R10 serial after parallel",
              {locked, mode_serial}, 2);

        // R4: nominal frame at each rate
        for (int r = 0; r < 4; r++) begin
            int d;
            d = SIM_HZ / rate_of(r);
            do_reset(); enter();
            send_frame(d, d, 8'h0D, 1'b1, 2 * d);
            check(locked && mode_serial, "R4 serial lock", {locked, mode_serial}, 3);
            check(int'(baud_div) == d, "R4 divisor", int'(baud_div), d);
        end

        // R10 and R8: program pulse and reset release after serial lock
        pulse_prog();
        @(negedge clk); rst_pin = 1'b0; wait_n(6);
        check(locked && mode_serial && int'(baud_div) == SIM_HZ / 300, "R10 R8 hold serial lock",
              int'(baud_div), SIM_HZ / 300);

        // R5: width sweep around the fastest window (D=10, window 8..12)
        for (int w = 5; w <= 16; w++) begin
            bit exp;
            exp = (w >= 8) && (w <= 12);
            do_reset(); enter();
            send_frame(w, 10, 8'h0D, 1'b1, 30);
            check(locked == exp, "R5 fast window", locked, exp);
            if (exp) check(int'(baud_div) == 10, "R5 fast divisor", int'(baud_div), 10);
        end

        // R5: edges of the slowest window (D=320, window 240..400)
        begin
            int ws[4];
            ws = '{239, 240, 400, 401};
            for (int k = 0; k < 4; k++) begin
                bit exp;
                exp = (ws[k] >= 240) && (ws[k] <= 400);
                do_reset(); enter();
                send_frame(ws[k], 320, 8'h0D, 1'b1, exp ? 40 : 12 * 320);
                check(locked == exp, "R5 slow window", locked, exp);
            end
        end

        // R6: wrong byte, then a good frame
        do_reset(); enter();
        send_frame(10, 10, 8'h0F, 1'b1, 480);
        check(!locked && loader_active, "R6 wrong byte", locked, 0);
        send_frame(10, 10, 8'h0D, 1'b1, 20);
        check(locked && int'(baud_div) == 10, "R6 relock after bad byte", locked, 1);

        // R6: bad stop bit, then a good frame at 2400
        do_reset(); enter();
        send_frame(10, 10, 8'h0D, 1'b0, 480);
        check(!locked && loader_active, "R6 bad stop", locked, 0);
        send_frame(40, 40, 8'h0D, 1'b1, 80);
        check(locked && int'(baud_div) == 40, "R6 relock after bad stop", int'(baud_div), 40);

        // R8: hold until block reset
        @(negedge clk); rst_pin = 1'b0; wait_n(10);
        check(locked && mode_serial, "R8 lock kept", locked, 1);
        do_reset();
        check(!locked && !loader_active, "R8 cleared by block reset", locked, 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule